// File: doc/BRIEF.md
# Camera Trigger Source and Delay Generator

This block produces the one-cycle trigger pulses that start sensor exposures. It runs on the pixel clock. It takes its events from one of four sources: an asynchronous external input, an asynchronous camera-control line, a software command bit, or an internal rate generator that runs on its own. The source is chosen by a register.

After an event, the block waits for a programmable delay. The delay is written in nanoseconds and is turned into whole pixel-clock cycles when the register is written. The block then emits a single pulse, a counted run of pulses, or an endless train of pulses. The spacing between pulses comes from a rate programmed in hertz.

Configuration arrives over a simple write-only port: an enable, an address and data. An event that arrives while a delay or a run is still in progress is dropped and latches an overrun flag.

Top module: `cam_trig_gen`

## Requirements
- R1: After reset, the trigger output and the overrun flag are low. The defaults are: source code 4 (free-running), rate 10 Hz, mode 0 (sequence), run length 1 and delay 0. With a 100 MHz pixel clock, no pulse appears within the first few hundred cycles.
- R2: Address 0x103 selects the source: 0 none, 1 external input, 2 camera-control line, 3 software, 4 free-running (codes 5 to 7 act as none). Events from sources that are not selected produce no pulse.
- R3: Writing address 0x200 with bit 0 set is a software event. With an idle block, source 3 and D delay cycles, the pulse is high in the cycle that begins D+1 clock edges after the edge that samples the write.
- R4: The external and camera-control inputs each pass through a two-flop synchronizer. Only a rising edge is an event, so a level held high gives one pulse. The pulse starts D+3 edges after the input first goes high.
- R5: Address 0x104 holds the delay in ns. The cycle count applied is floor(ns × f_clk / 1e9), so at 100 MHz it is ns/10 rounded down.
- R6: Each pulse on trig_o lasts exactly one clock cycle. Two pulses are always separated by at least one low cycle.
- R7: Address 0x108 holds a rate R in Hz. With source 4, an event occurs every f_clk/R cycles (10 cycles for R = 10,000,000 at 100 MHz). A write to this address restarts the rate phase.
- R8: Address 0x10A selects the mode: 0 sequence, 1 single, 2 continuous. In sequence mode one event gives N pulses, where N is the value at address 0x10B (0 counts as 1); the first pulse comes after the delay and the rest follow every f_clk/R cycles. Single mode gives one pulse. Continuous mode repeats every f_clk/R cycles until address 0x10A or 0x103 is written, and such a write aborts any activity in progress.
- R9: An event that arrives during a delay, a run, or the cycle of a pulse is ignored and sets overrun_o. overrun_o stays high until a write to 0x200 with bit 1 set clears it at that write's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| ext_trig_i | input | 1 | Asynchronous external trigger input |
| cc1_trig_i | input | 1 | Asynchronous camera-control trigger line |
| trig_o | output | 1 | Sensor trigger pulse, one cycle wide |
| overrun_o | output | 1 | Sticky flag for a dropped event |

## Verification
A wrong delay conversion or a countdown that is off by one shows up as the next pulse moving by whole cycles relative to its event. The delay sweep catches this on the first affected nanosecond value. A busy state that never clears appears at the next event as a missing pulse and a rising overrun flag. A faulty phase accumulator shows within one rate period as pulse spacing that differs from f_clk/R. An abort that does not take effect shows as continuous pulses going on after the mode write.

// File: rtl/cam_trig_pkg.sv
package cam_trig_pkg;
  typedef enum logic [2:0] {
    SRC_OFF  = 3'd0,
    SRC_EXT  = 3'd1,
    SRC_CC1  = 3'd2,
    SRC_SW   = 3'd3,
    SRC_FREE = 3'd4
  } src_e;

  typedef enum logic [1:0] {
    MODE_SEQ  = 2'd0,
    MODE_ONE  = 2'd1,
    MODE_CONT = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DELAY,
    ST_BURST
  } st_e;

  localparam logic [11:0] A_SRC  = 12'h103;
  localparam logic [11:0] A_DLY  = 12'h104;
  localparam logic [11:0] A_RATE = 12'h108;
  localparam logic [11:0] A_MODE = 12'h10A;
  localparam logic [11:0] A_CNT  = 12'h10B;
  localparam logic [11:0] A_CTRL = 12'h200;

  // fixed-point position of the ns->cycle reciprocal
  localparam int unsigned RECIP_SHIFT = 62;
  localparam int unsigned RECIP_W     = 66;
endpackage

// File: rtl/cam_trig_sync.sv
module cam_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-1:0], async_i};
  end

  assign rise_o = q[STAGES-1] & ~q[STAGES];
endmodule

// File: rtl/cam_trig_regs.sv
module cam_trig_regs
  import cam_trig_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [2:0]        src_o,
  output logic [DATA_W-1:0] dly_ns_o,
  output logic [DATA_W-1:0] dly_cyc_o,
  output logic [DATA_W-1:0] rate_o,
  output logic [DATA_W-1:0] count_o,
  output logic [1:0]        mode_o,
  output logic              sw_evt_o,
  output logic              ovr_clr_o,
  output logic              rate_wr_o,
  output logic              abort_o
);
  localparam int unsigned PROD_W = DATA_W + RECIP_W;
  localparam logic [127:0] RECIP_NUM = (128'(CLK_HZ) << RECIP_SHIFT) + 128'd999_999_999;
  localparam logic [RECIP_W-1:0] RECIP = RECIP_W'(RECIP_NUM / 128'd1_000_000_000);

  logic wr_src, wr_dly, wr_rate, wr_mode, wr_cnt, wr_ctrl;
  logic [PROD_W-1:0] prod;

  always_comb begin
    wr_src  = wr_en_i && (wr_addr_i == ADDR_W'(A_SRC));
    wr_dly  = wr_en_i && (wr_addr_i == ADDR_W'(A_DLY));
    wr_rate = wr_en_i && (wr_addr_i == ADDR_W'(A_RATE));
    wr_mode = wr_en_i && (wr_addr_i == ADDR_W'(A_MODE));
    wr_cnt  = wr_en_i && (wr_addr_i == ADDR_W'(A_CNT));
    wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));
  end

  // one multiply per write; rounding up the reciprocal keeps the floor exact
  assign prod = PROD_W'(wr_data_i) * PROD_W'(RECIP);

  assign ovr_clr_o = wr_ctrl && wr_data_i[1];
  assign rate_wr_o = wr_rate;
  assign abort_o   = wr_src || wr_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o     <= 3'(SRC_FREE);
      dly_ns_o  <= '0;
      dly_cyc_o <= '0;
      rate_o    <= DATA_W'(10);
      count_o   <= DATA_W'(1);
      mode_o    <= 2'(MODE_SEQ);
      sw_evt_o  <= 1'b0;
    end else begin
      sw_evt_o <= wr_ctrl && wr_data_i[0];
      if (wr_src)  src_o   <= wr_data_i[2:0];
      if (wr_rate) rate_o  <= wr_data_i;
      if (wr_mode) mode_o  <= wr_data_i[1:0];
      if (wr_cnt)  count_o <= wr_data_i;
      if (wr_dly) begin
        dly_ns_o  <= wr_data_i;
        dly_cyc_o <= prod[RECIP_SHIFT +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/cam_trig_rate.sv
module cam_trig_rate #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] rate_i,
  output logic              tick_o
);
  localparam logic [DATA_W:0] LIM = (DATA_W+1)'(CLK_HZ);

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W:0]   sum;
  logic              wrap;

  assign sum    = {1'b0, acc_q} + {1'b0, rate_i};
  assign wrap   = sum >= LIM;
  assign tick_o = en_i && wrap;

  // phase accumulator: exact average rate, no divide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 acc_q <= '0;
    else if (clr_i || !en_i)     acc_q <= '0;
    else if (!wrap)              acc_q <= sum[DATA_W-1:0];
    else if ({1'b0, rate_i} >= LIM) acc_q <= '0;
    else                         acc_q <= DATA_W'(sum - LIM);
  end
endmodule

// File: rtl/cam_trig_seq.sv
module cam_trig_seq
  import cam_trig_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [DATA_W-1:0] dly_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic              tick_i,
  input  logic              abort_i,
  input  logic              ovr_clr_i,
  output logic              burst_en_o,
  output logic              busy_o,
  output logic              trig_o,
  output logic              overrun_o
);
  st_e               st_q, st_d;
  logic [DATA_W-1:0] cnt_q, cnt_d, left_q, left_d;
  logic              trig_q, emit, launch, ovr_q, ovr_d;

  assign busy_o     = (st_q != ST_IDLE) || trig_q;
  assign burst_en_o = (st_q == ST_BURST);
  assign trig_o     = trig_q;
  assign overrun_o  = ovr_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    left_d = left_q;
    emit   = 1'b0;
    launch = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (evt_i && !trig_q) begin
          if (dly_i == '0) launch = 1'b1;
          else begin
            st_d  = ST_DELAY;
            cnt_d = dly_i - 1'b1;
          end
        end
      end
      ST_DELAY: begin
        if (cnt_q == '0) launch = 1'b1;
        else             cnt_d  = cnt_q - 1'b1;
      end
      ST_BURST: begin
        if (tick_i && !trig_q) begin
          emit = 1'b1;
          if (mode_i != 2'(MODE_CONT)) begin
            left_d = left_q - 1'b1;
            if (left_q <= DATA_W'(1)) st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (launch) begin
      emit = 1'b1;
      if (mode_i == 2'(MODE_CONT)) st_d = ST_BURST;
      else if (mode_i == 2'(MODE_SEQ) && count_i > DATA_W'(1)) begin
        st_d   = ST_BURST;
        left_d = count_i - 1'b1;
      end else st_d = ST_IDLE;
    end

    if (abort_i) begin
      st_d = ST_IDLE;
      emit = 1'b0;
    end

    ovr_d = ovr_q;
    if (ovr_clr_i)       ovr_d = 1'b0;
    if (evt_i && busy_o) ovr_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      left_q <= '0;
      trig_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
      trig_q <= emit;
      ovr_q  <= ovr_d;
    end
  end
endmodule

// File: rtl/cam_trig_gen.sv
module cam_trig_gen
  import cam_trig_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ext_trig_i,
  input  logic              cc1_trig_i,
  output logic              trig_o,
  output logic              overrun_o
);
  localparam int unsigned N_LINES = 2;
  localparam int unsigned N_RATE  = 2;

  logic [2:0]        src_w;
  logic [1:0]        mode_w;
  logic [DATA_W-1:0] dly_ns_w, dly_cyc_w, rate_w, count_w;
  logic              sw_evt_w, ovr_clr_w, rate_wr_w, abort_w;
  logic              burst_en_w, busy_w, evt_w;
  logic [N_LINES-1:0] raw_w, rise_w;
  logic [N_RATE-1:0]  rg_en, rg_tick;

  cam_trig_regs #(.CLK_HZ(CLK_HZ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .src_o     (src_w),
    .dly_ns_o  (dly_ns_w),
    .dly_cyc_o (dly_cyc_w),
    .rate_o    (rate_w),
    .count_o   (count_w),
    .mode_o    (mode_w),
    .sw_evt_o  (sw_evt_w),
    .ovr_clr_o (ovr_clr_w),
    .rate_wr_o (rate_wr_w),
    .abort_o   (abort_w)
  );

  assign raw_w = {cc1_trig_i, ext_trig_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    cam_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (raw_w[g]),
      .rise_o  (rise_w[g])
    );
  end

  // [0] free-running source, [1] run spacing
  assign rg_en = {burst_en_w, src_w == 3'(SRC_FREE)};

  for (genvar g = 0; g < N_RATE; g++) begin : g_rate
    cam_trig_rate #(.CLK_HZ(CLK_HZ), .DATA_W(DATA_W)) u_rate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (rg_en[g]),
      .clr_i  (rate_wr_w),
      .rate_i (rate_w),
      .tick_o (rg_tick[g])
    );
  end

  always_comb begin
    case (src_w)
      3'(SRC_EXT):  evt_w = rise_w[0];
      3'(SRC_CC1):  evt_w = rise_w[1];
      3'(SRC_SW):   evt_w = sw_evt_w;
      3'(SRC_FREE): evt_w = rg_tick[0];
      default:      evt_w = 1'b0;
    endcase
  end

  cam_trig_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_w),
    .dly_i      (dly_cyc_w),
    .mode_i     (mode_w),
    .count_i    (count_w),
    .tick_i     (rg_tick[1]),
    .abort_i    (abort_w),
    .ovr_clr_i  (ovr_clr_w),
    .burst_en_o (burst_en_w),
    .busy_o     (busy_w),
    .trig_o     (trig_o),
    .overrun_o  (overrun_o)
  );
endmodule

// File: rtl/cam_trig_gen_chk.sv
module cam_trig_gen_chk
  import cam_trig_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              trig_o,
  input logic              overrun_o,
  input logic [2:0]        src_i,
  input logic              busy_i,
  input logic              evt_i,
  input logic              sw_evt_i,
  input logic [DATA_W-1:0] dly_ns_i,
  input logic [DATA_W-1:0] dly_cyc_i
);
  logic [127:0] ref_w, lo_w, hi_w;
  logic         ctrl_fire_w, ovr_clr_w, cfg_wr_w;

  assign ref_w = 128'(dly_ns_i) * 128'(CLK_HZ);
  assign lo_w  = 128'(dly_cyc_i) * 128'd1_000_000_000;
  assign hi_w  = lo_w + 128'd1_000_000_000;

  assign ctrl_fire_w = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL)) && wr_data_i[0];
  assign ovr_clr_w   = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL)) && wr_data_i[1];
  assign cfg_wr_w    = wr_en_i && ((wr_addr_i == ADDR_W'(A_SRC)) || (wr_addr_i == ADDR_W'(A_MODE)));

  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o); // R6

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == 3'(SRC_OFF) && !busy_i) |=> !trig_o); // R2

  AST_DLY_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_w <= ref_w) && (hi_w > ref_w)); // R5

  AST_SW_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctrl_fire_w && src_i == 3'(SRC_SW) && !busy_i && !sw_evt_i && dly_cyc_i == '0)
     && !cfg_wr_w) |=> trig_o); // R3

  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && busy_i) |=> overrun_o); // R9

  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !ovr_clr_w) |=> overrun_o); // R9
endmodule

bind cam_trig_gen cam_trig_gen_chk #(
  .CLK_HZ(CLK_HZ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .trig_o    (trig_o),
  .overrun_o (overrun_o),
  .src_i     (src_w),
  .busy_i    (busy_w),
  .evt_i     (evt_w),
  .sw_evt_i  (sw_evt_w),
  .dly_ns_i  (dly_ns_w),
  .dly_cyc_i (dly_cyc_w)
);

// File: tb/tb_cam_trig_gen.sv
module tb_cam_trig_gen;
  localparam logic [11:0] AD_SRC  = 12'h103;
  localparam logic [11:0] AD_DLY  = 12'h104;
  localparam logic [11:0] AD_RATE = 12'h108;
  localparam logic [11:0] AD_MODE = 12'h10A;
  localparam logic [11:0] AD_CNT  = 12'h10B;
  localparam logic [11:0] AD_CTRL = 12'h200;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        ext_trig = 1'b0;
  logic        cc1_trig = 1'b0;
  logic        trig, overrun;

  int n_chk = 0;
  int n_fail = 0;
  int pos[32];
  int npos;
  int lat;

  always #5 clk = ~clk;

  cam_trig_gen dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .ext_trig_i (ext_trig),
    .cc1_trig_i (cc1_trig),
    .trig_o     (trig),
    .overrun_o  (overrun)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_trig(input int max);
    lat = -1;
    for (int i = 1; i <= max; i++) begin
      @(negedge clk);
      if (trig) begin lat = i; break; end
    end
  endtask

  task automatic rec(input int n);
    npos = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (trig) begin
        if (npos < 32) pos[npos] = i;
        npos++;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    report();
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    // R1 reset state and quiet 10 Hz default
    chk(trig == 1'b0, "R1 trig", trig, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    rec(300);
    chk(npos == 0, "R1 no pulse", npos, 0);

    // R3 R5 R6 sweep: single mode, software source
    wr(AD_MODE, 1);
    wr(AD_SRC, 3);
    for (int ns = 0; ns <= 300; ns++) begin
      wr(AD_DLY, ns);
      wr(AD_CTRL, 1);
      wait_trig(60);
      chk(lat == ns / 10 + 1, "R5 R3 latency", lat, ns / 10 + 1);
      @(negedge clk);
      chk(trig == 1'b0, "R6 width", trig, 0);
      idle(2);
    end
    chk(overrun == 1'b0, "R9 no overrun in sweep", overrun, 0);

    // R2 external line ignored while software selected
    wr(AD_DLY, 0);
    ext_trig = 1'b1;
    rec(20);
    ext_trig = 1'b0;
    chk(npos == 0, "R2 ext ignored", npos, 0);
    // R2 source none ignores software
    wr(AD_SRC, 0);
    wr(AD_CTRL, 1);
    rec(20);
    chk(npos == 0, "R2 off", npos, 0);

    // R4 external, level held high gives one pulse
    wr(AD_SRC, 1);
    idle(4);
    @(negedge clk); ext_trig = 1'b1;
    wait_trig(30);
    chk(lat == 3, "R4 ext latency", lat, 3);
    rec(30);
    chk(npos == 0, "R4 held level", npos, 0);
    ext_trig = 1'b0;
    idle(4);
    wr(AD_DLY, 40);
    @(negedge clk); ext_trig = 1'b1;
    wait_trig(30);
    chk(lat == 7, "R4 ext delayed", lat, 7);
    ext_trig = 1'b0;
    idle(4);

    // R4 camera-control line; R2 others ignored
    wr(AD_DLY, 0);
    wr(AD_SRC, 2);
    idle(4);
    @(negedge clk); cc1_trig = 1'b1;
    wait_trig(30);
    chk(lat == 3, "R4 cc1 latency", lat, 3);
    cc1_trig = 1'b0;
    idle(4);
    ext_trig = 1'b1;
    wr(AD_CTRL, 1);
    rec(20);
    ext_trig = 1'b0;
    chk(npos == 0, "R2 cc1 only", npos, 0);

    // R8 sequence run of 3, spacing 10, delay 2
    wr(AD_RATE, 10_000_000);
    wr(AD_MODE, 0);
    wr(AD_CNT, 3);
    wr(AD_DLY, 20);
    wr(AD_SRC, 3);
    wr(AD_CTRL, 1);
    rec(80);
    chk(npos == 3, "R8 run length", npos, 3);
    chk(pos[0] == 3, "R8 first", pos[0], 3);
    chk(pos[1] == 13, "R8 second", pos[1], 13);
    chk(pos[2] == 23, "R8 third", pos[2], 23);
    chk(overrun == 1'b0, "R9 clean run", overrun, 0);

    // R9 second event during run is dropped
    wr(AD_CTRL, 1);
    wr(AD_CTRL, 1);
    rec(80);
    chk(npos == 3, "R9 dropped event", npos, 3);
    chk(pos[0] == 1 && pos[1] == 11 && pos[2] == 21, "R9 run unchanged", pos[2], 21);
    chk(overrun == 1'b1, "R9 set", overrun, 1);
    idle(20);
    chk(overrun == 1'b1, "R9 sticky", overrun, 1);
    wr(AD_CTRL, 2);
    chk(overrun == 1'b0, "R9 clear", overrun, 0);
    rec(20);
    chk(npos == 0, "R9 clear no pulse", npos, 0);

    // R8 count 0 acts as 1
    wr(AD_CNT, 0);
    wr(AD_DLY, 0);
    wr(AD_CTRL, 1);
    rec(50);
    chk(npos == 1, "R8 count zero", npos, 1);

    // R7 free-running
    wr(AD_MODE, 1);
    wr(AD_SRC, 4);
    rec(62);
    chk(npos >= 5, "R7 count", npos, 6);
    for (int j = 1; j < npos && j < 32; j++)
      chk(pos[j] - pos[j-1] == 10, "R7 spacing 10", pos[j] - pos[j-1], 10);
    wr(AD_RATE, 20_000_000);
    rec(41);
    chk(npos >= 7, "R7 fast count", npos, 8);
    for (int j = 1; j < npos && j < 32; j++)
      chk(pos[j] - pos[j-1] == 5, "R7 spacing 5", pos[j] - pos[j-1], 5);
    wr(AD_SRC, 3);
    rec(30);
    chk(npos == 0, "R2 free deselected", npos, 0);

    // R8 continuous until mode write
    wr(AD_RATE, 10_000_000);
    wr(AD_MODE, 2);
    wr(AD_CTRL, 1);
    rec(100);
    chk(npos == 10, "R8 continuous count", npos, 10);
    chk(pos[0] == 1, "R8 continuous first", pos[0], 1);
    for (int j = 1; j < npos && j < 32; j++)
      chk(pos[j] - pos[j-1] == 10, "R8 continuous spacing", pos[j] - pos[j-1], 10);
    wr(AD_MODE, 1);
    rec(40);
    chk(npos == 0, "R8 abort", npos, 0);

    report();
  end
endmodule